// File: doc/BRIEF.md
# Vector Status Register Controller

This block owns the 64-bit status word of a vector unit and carries out the short control operations that read or rewrite it. The word holds a mask-mode bit, the current vector count, the vector interruption index, and two 8-bit flag sets, one per register pair: an in-use set and a changed set. A sequencer presents an opcode with `op_valid`, together with a 32-bit operand (a signed value or a pair mask) or a 64-bit restore word, and a flag saying whether the program runs in problem state. One cycle later the block raises `done` and shows the updated word, a 2-bit condition code, a 32-bit result, any pair-clear requests and any specification error.

Signed operands are clamped into the range 0..`SECT` before they are stored, and a four-way condition code reports how the operand related to that range. A restore validates the incoming word before it accepts it. In problem state it also rewrites the changed flags from the in-use flags. It asks the register file to clear any pair whose in-use flag drops. The vector registers themselves live outside this block, which only issues the clear requests.

Status word layout: bit 48 mask mode, bits 47:32 vector count, bits 31:16 interruption index, bits 15:8 in-use flags (pair 0 at bit 15, pair 14 at bit 8), bits 7:0 changed flags (pair 0 at bit 7), bits 63:49 reserved. Opcodes: 0 load count, 1 load index, 2 set mask mode, 3 clear pairs, 4 restore, 5 extract count, 6 extract modes, 7 store parameters; 8..15 are undefined.

Top module: `vsr_ctrl`

## Requirements
- R1: After reset the status word, condition code, result, clear requests, specification error and done are all zero.
- R2: `done` is high for exactly one cycle, in the cycle after each cycle with `op_valid` high, and low otherwise.
- R3: Load count (opcode 0) sets cc 0 for a zero operand, 1 for a negative operand, 2 for an operand above `SECT` and 3 otherwise. It writes the operand clamped to 0..`SECT` into bits 47:32 and leaves the other bits unchanged.
- R4: Load index (opcode 1) sets cc 0 for zero, 1 for negative, 2 when the operand is below the current count and 3 otherwise. It writes the operand clamped to 0..`SECT` into bits 31:16.
- R5: Set mask mode (opcode 2) copies operand bit 0 into status bit 48 and leaves cc unchanged.
- R6: Clear pairs (opcode 3) zeroes bits 31:16. For each set operand bit j in 7:0 it clears in-use bit 8+j, so operand bit 7 selects pair 0 and bit 0 selects pair 14. It drives `clear_req` equal to operand bits 7:0 for one cycle.
- R7: A restore (opcode 4) whose word has any of bits 63:49 set, a count above `SECT`, or an index of `SECT` or more pulses `spec_err`. It leaves the status word unchanged and issues no clear request.
- R8: A valid restore loads the word as given when `prob_state` is low. When `prob_state` is high, bits 7:0 are replaced with bits 15:8 of the word.
- R9: A valid restore drives `clear_req` with the old in-use flags AND the inverse of the new in-use flags, in the same bit order as bits 15:8.
- R10: Extract count (opcode 5) returns the count zero-extended. Extract modes (opcode 6) returns status bits 63:48 zero-extended.
- R11: Store parameters (opcode 7) returns `SECT` in bits 31:16 and `PSUM` in bits 15:0.
- R12: Opcodes 8..15, and opcodes that define no cc or result, leave the status word, cc and result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select |
| op_arg | input | 32 | Signed operand or pair mask |
| restore_word | input | 64 | Status word offered by a restore |
| prob_state | input | 1 | Problem-state flag |
| status | output | 64 | Current status word |
| cc | output | 2 | Condition code |
| result | output | 32 | Extract and parameter result |
| clear_req | output | 8 | Per-pair clear request pulse |
| spec_err | output | 1 | Specification error pulse |
| done | output | 1 | Operation complete pulse |

## Verification
The hardest state to reach is a problem-state restore in which in-use flags drop while the changed flags in the offered word disagree with the in-use flags. Only a restore can set in-use flags, so the stimulus first restores a word with several in-use flags set and changed flags set differently. It then issues a problem-state restore that keeps some of those flags and drops others, and checks both the rewritten changed flags and the clear request. Rejected restores follow directly, so that each error is seen against a non-trivial status word that must survive unchanged.

// File: rtl/vsr_ctrl.sv
module vsr_ctrl #(
  parameter int SECT = 128,
  parameter int PSUM = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [3:0]  op_code,
  input  logic [31:0] op_arg,
  input  logic [63:0] restore_word,
  input  logic        prob_state,
  output logic [63:0] status,
  output logic [1:0]  cc,
  output logic [31:0] result,
  output logic [7:0]  clear_req,
  output logic        spec_err,
  output logic        done
);
  localparam logic [31:0] SECT32 = 32'(SECT);
  localparam logic [15:0] SECT16 = 16'(SECT);
  localparam logic [15:0] PSUM16 = 16'(PSUM);

  localparam logic [3:0] OP_LDCNT = 4'd0;
  localparam logic [3:0] OP_LDIDX = 4'd1;
  localparam logic [3:0] OP_MASK  = 4'd2;
  localparam logic [3:0] OP_CLR   = 4'd3;
  localparam logic [3:0] OP_REST  = 4'd4;
  localparam logic [3:0] OP_XCNT  = 4'd5;
  localparam logic [3:0] OP_XMOD  = 4'd6;
  localparam logic [3:0] OP_PARM  = 4'd7;

  logic [15:0] cur_cnt;
  assign cur_cnt = status[47:32];

  logic arg_neg, arg_zero, arg_big;
  logic [15:0] arg_clamp;
  assign arg_neg   = op_arg[31];
  assign arg_zero  = (op_arg == 32'd0);
  assign arg_big   = !arg_neg && (op_arg > SECT32);
  assign arg_clamp = arg_neg ? 16'd0 : (arg_big ? SECT16 : op_arg[15:0]);

  logic idx_below;
  assign idx_below = !arg_neg && (op_arg < {16'd0, cur_cnt});

  logic [1:0] cc_cnt, cc_idx;
  assign cc_cnt = arg_zero ? 2'd0 : arg_neg ? 2'd1 : arg_big   ? 2'd2 : 2'd3;
  assign cc_idx = arg_zero ? 2'd0 : arg_neg ? 2'd1 : idx_below ? 2'd2 : 2'd3;

  logic rw_bad;
  assign rw_bad = (|restore_word[63:49])
                | (restore_word[47:32] > SECT16)
                | (restore_word[31:16] >= SECT16);

  logic [63:0] rw_eff;
  assign rw_eff = prob_state ? {restore_word[63:8], restore_word[15:8]} : restore_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status    <= '0;
      cc        <= '0;
      result    <= '0;
      clear_req <= '0;
      spec_err  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done      <= op_valid;
      clear_req <= '0;
      spec_err  <= 1'b0;
      if (op_valid) begin
        case (op_code)
          OP_LDCNT: begin
            status[47:32] <= arg_clamp;
            cc            <= cc_cnt;
          end
          OP_LDIDX: begin
            status[31:16] <= arg_clamp;
            cc            <= cc_idx;
          end
          OP_MASK: status[48] <= op_arg[0];
          OP_CLR: begin
            status[31:16] <= '0;
            status[15:8]  <= status[15:8] & ~op_arg[7:0];
            clear_req     <= op_arg[7:0];
          end
          OP_REST: begin
            if (rw_bad) begin
              spec_err <= 1'b1;
            end else begin
              status    <= rw_eff;
              clear_req <= status[15:8] & ~restore_word[15:8];
            end
          end
          OP_XCNT: result <= {16'd0, cur_cnt};
          OP_XMOD: result <= {16'd0, status[63:48]};
          OP_PARM: result <= {SECT16, PSUM16};
          default: ;
        endcase
      end
    end
  end

  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !done);
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[47:32] <= SECT16);
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status[31:16] <= SECT16);
  p_zero_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LDCNT && op_arg == 32'd0) |=> (cc == 2'd0 && status[47:32] == 16'd0));
  p_mask_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MASK) |=> (status[48] == $past(op_arg[0]) && $stable(cc)));
  p_err_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spec_err |-> (status == $past(status) && clear_req == 8'd0));
  p_clr_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req != 8'd0) |-> done);
  p_undef_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[3]) |=> ($stable(status) && $stable(cc) && $stable(result)));
endmodule

// File: tb/vsr_ctrl_bench.sv
module vsr_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, op_valid, prob_state;
  logic [3:0]  op_code;
  logic [31:0] op_arg;
  logic [63:0] restore_word;
  logic [63:0] status;
  logic [1:0]  cc;
  logic [31:0] result;
  logic [7:0]  clear_req;
  logic        spec_err, done;

  vsr_ctrl #(.SECT(128), .PSUM(8)) u_vsr_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_arg(op_arg), .restore_word(restore_word), .prob_state(prob_state),
    .status(status), .cc(cc), .result(result), .clear_req(clear_req),
    .spec_err(spec_err), .done(done));

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [31:0] arg;
    logic [63:0] word;
    logic        prob;
    logic [63:0] e_st;
    logic [1:0]  e_cc;
    logic [31:0] e_res;
    logic [7:0]  e_clr;
    logic        e_err;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{4'd3,  4'd0, 32'h0000_0000, 64'h0, 1'b0, 64'h0000_0000_0000_0000, 2'd0, 32'h0, 8'h00, 1'b0}, // R3 zero
    '{4'd3,  4'd0, 32'h0000_0032, 64'h0, 1'b0, 64'h0000_0032_0000_0000, 2'd3, 32'h0, 8'h00, 1'b0}, // R3 in range
    '{4'd3,  4'd0, 32'hFFFF_FFFB, 64'h0, 1'b0, 64'h0000_0000_0000_0000, 2'd1, 32'h0, 8'h00, 1'b0}, // R3 negative
    '{4'd3,  4'd0, 32'h0000_00C8, 64'h0, 1'b0, 64'h0000_0080_0000_0000, 2'd2, 32'h0, 8'h00, 1'b0}, // R3 above
    '{4'd3,  4'd0, 32'h0000_0080, 64'h0, 1'b0, 64'h0000_0080_0000_0000, 2'd3, 32'h0, 8'h00, 1'b0}, // R3 equal
    '{4'd4,  4'd1, 32'h0000_000A, 64'h0, 1'b0, 64'h0000_0080_000A_0000, 2'd2, 32'h0, 8'h00, 1'b0}, // R4 below count
    '{4'd4,  4'd1, 32'h0000_0080, 64'h0, 1'b0, 64'h0000_0080_0080_0000, 2'd3, 32'h0, 8'h00, 1'b0}, // R4 equal count
    '{4'd4,  4'd1, 32'h0000_012C, 64'h0, 1'b0, 64'h0000_0080_0080_0000, 2'd3, 32'h0, 8'h00, 1'b0}, // R4 clamp
    '{4'd4,  4'd1, 32'hFFFF_FFFF, 64'h0, 1'b0, 64'h0000_0080_0000_0000, 2'd1, 32'h0, 8'h00, 1'b0}, // R4 negative
    '{4'd5,  4'd2, 32'h0000_0003, 64'h0, 1'b0, 64'h0001_0080_0000_0000, 2'd1, 32'h0, 8'h00, 1'b0}, // R5
    '{4'd10, 4'd6, 32'h0, 64'h0, 1'b0, 64'h0001_0080_0000_0000, 2'd1, 32'h0000_0001, 8'h00, 1'b0}, // R10 modes
    '{4'd10, 4'd5, 32'h0, 64'h0, 1'b0, 64'h0001_0080_0000_0000, 2'd1, 32'h0000_0080, 8'h00, 1'b0}, // R10 count
    '{4'd11, 4'd7, 32'h0, 64'h0, 1'b0, 64'h0001_0080_0000_0000, 2'd1, 32'h0080_0008, 8'h00, 1'b0}, // R11
    '{4'd8,  4'd4, 32'h0, 64'h0000_0040_0005_F0A0, 1'b0, 64'h0000_0040_0005_F0A0, 2'd1, 32'h0080_0008, 8'h00, 1'b0}, // R8 supervisor
    '{4'd9,  4'd4, 32'h0, 64'h0001_0010_0003_3C00, 1'b1, 64'h0001_0010_0003_3C3C, 2'd1, 32'h0080_0008, 8'hC0, 1'b0}, // R8 R9 problem state
    '{4'd7,  4'd4, 32'h0, 64'h0002_0000_0000_0000, 1'b0, 64'h0001_0010_0003_3C3C, 2'd1, 32'h0080_0008, 8'h00, 1'b1}, // R7 reserved
    '{4'd7,  4'd4, 32'h0, 64'h0000_0081_0000_0000, 1'b0, 64'h0001_0010_0003_3C3C, 2'd1, 32'h0080_0008, 8'h00, 1'b1}, // R7 count
    '{4'd7,  4'd4, 32'h0, 64'h0000_0000_0080_0000, 1'b0, 64'h0001_0010_0003_3C3C, 2'd1, 32'h0080_0008, 8'h00, 1'b1}, // R7 index
    '{4'd6,  4'd3, 32'h0000_0024, 64'h0, 1'b0, 64'h0001_0010_0000_183C, 2'd1, 32'h0080_0008, 8'h24, 1'b0}, // R6
    '{4'd12, 4'd9, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0001_0010_0000_183C, 2'd1, 32'h0080_0008, 8'h00, 1'b0}, // R12
    '{4'd10, 4'd5, 32'h0, 64'h0, 1'b0, 64'h0001_0010_0000_183C, 2'd1, 32'h0000_0010, 8'h00, 1'b0}, // R10
    '{4'd9,  4'd4, 32'h0, 64'h0000_0080_007F_FF00, 1'b0, 64'h0000_0080_007F_FF00, 2'd1, 32'h0000_0010, 8'h00, 1'b0}, // R7 R9 limits
    '{4'd6,  4'd3, 32'h0000_00FF, 64'h0, 1'b0, 64'h0000_0080_0000_0000, 2'd1, 32'h0000_0010, 8'hFF, 1'b0}, // R6 all
    '{4'd4,  4'd1, 32'h0000_0000, 64'h0, 1'b0, 64'h0000_0080_0000_0000, 2'd0, 32'h0000_0010, 8'h00, 1'b0}  // R4 zero
  };

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] arg,
                       input logic [63:0] word, input logic prob);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_arg = arg; restore_word = word; prob_state = prob;
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd0; op_arg = '0; restore_word = '0; prob_state = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_arg = '0; restore_word = '0; prob_state = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", status, 64'h0);
    chk("R1 cc", {62'd0, cc}, 64'h0);
    chk("R1 result", {32'd0, result}, 64'h0);
    chk("R1 flags", {54'd0, clear_req, spec_err, done}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i].op, TBL[i].arg, TBL[i].word, TBL[i].prob);
      chk($sformatf("R%0d row %0d status", TBL[i].req, i), status, TBL[i].e_st);
      chk($sformatf("R%0d row %0d cc", TBL[i].req, i), {62'd0, cc}, {62'd0, TBL[i].e_cc});
      chk($sformatf("R%0d row %0d result", TBL[i].req, i), {32'd0, result}, {32'd0, TBL[i].e_res});
      chk($sformatf("R%0d row %0d clear_req", TBL[i].req, i), {56'd0, clear_req}, {56'd0, TBL[i].e_clr});
      chk($sformatf("R%0d row %0d spec_err", TBL[i].req, i), {63'd0, spec_err}, {63'd0, TBL[i].e_err});
      chk($sformatf("R2 row %0d done", i), {63'd0, done}, 64'd1);
    end

    // R2: done and pulses drop in the idle cycle after an operation
    @(negedge clk);
    chk("R2 done idle", {63'd0, done}, 64'd0);
    chk("R6 clear_req one cycle", {56'd0, clear_req}, 64'd0);

    // R9 then R8: problem-state restore dropping pairs with disagreeing changed flags
    issue(4'd4, 32'h0, 64'h0000_0020_0001_AA55, 1'b0);
    chk("R8 plain restore", status, 64'h0000_0020_0001_AA55);
    issue(4'd4, 32'h0, 64'h0000_0020_0001_0FF0, 1'b1);
    chk("R8 changed rewritten", status, 64'h0000_0020_0001_0F0F);
    chk("R9 dropped pairs", {56'd0, clear_req}, 64'h0000_0000_0000_00A0);

    // R1: reset in the middle of activity returns everything to zero
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 status after reset", status, 64'h0);
    chk("R1 cc after reset", {62'd0, cc}, 64'h0);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule